// File: doc/BRIEF.md
# CAN receive mailbox matching engine

This block decides which of a set of receive mailboxes keeps an incoming CAN frame. Each mailbox holds a 3-bit code, a stored identifier, an extended-frame flag, its own acceptance mask, a serviced flag and a sticky interrupt flag. A frame arrives with its identifier and its extended flag. The engine then walks the mailboxes one per clock and picks a winner. It writes the frame's identifier into the winner, moves the winner's code to FULL or OVERRUN, sets the winner's interrupt flag, and reports the outcome on a one-cycle result pulse.

A mode pin selects the masking. With the pin low, one global mask is used and the first match wins. With the pin high, every mailbox uses its own mask. The first free match then wins. If no match is free, the last occupied match wins instead. The CPU sets up mailboxes through a write port. It locks one mailbox by reading its control/status word and releases it with an unlock pulse. A mailbox that was read and then unlocked while FULL or OVERRUN counts as serviced, which makes it free again.

Frames enter through a valid/ready handshake. `frm_ready` is high only while the engine is idle. A frame is taken on a cycle where `frm_valid` and `frm_ready` are both high. The identifier and flag must hold steady while `frm_valid` is high and `frm_ready` is low. No new frame is taken until the result of the current one has been reported. The result pins have no back-pressure. They are a status pulse.

Top module: `can_rx_match`

## Requirements
- R1: `frm_ready` is high after reset and whenever the engine is idle. After a frame is accepted it stays low until the cycle that carries the result pulse, where it is high again.
- R2: `res_valid` rises exactly NMB+1 clock edges after the accepting edge and is high for a single cycle. `res_hit` tells whether the frame was stored, and `res_idx` names the mailbox.
- R3: Each identifier bit is compared only where the active mask bit is 1. A cleared mask bit is don't-care, so an all-zero mask accepts any identifier. All IDW bits are compared, and a standard identifier sits in the low 11 bits.
- R4: A mailbox matches only if its extended flag equals the frame's flag. Standard frames (flag 0) and extended frames (flag 1) never share a receive mailbox.
- R5: With `indiv_en`=0, `glb_mask` applies to every mailbox. The winner is the lowest-indexed match, whether it is free or occupied.
- R6: With `indiv_en`=1, each mailbox's own mask applies. The winner is the lowest-indexed free match. If no match is free, it is the highest-indexed occupied match.
- R7: A mailbox is free when its code is EMPTY (1). It is also free when its code is FULL (2) or OVERRUN (3) and it was locked and then unlocked after its last store.
- R8: A store writes the frame identifier into the winner. A free winner becomes FULL (2). An occupied winner becomes OVERRUN (3).
- R9: Mailboxes with code INACTIVE (0) or TX (4) never match. A frame that matches nothing gives `res_hit`=0 and changes no code, identifier or interrupt flag.
- R10: A mailbox locked by the CPU is never stored into. The active rule picks the next candidate instead.
- R11: Each store sets that mailbox's bit in `irq_flags`. The bit stays set until a 1 is written to the same bit of `irq_clr`.
- R12: After reset every mailbox has code INACTIVE (0) and all interrupt flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| indiv_en | input | 1 | 1: per-mailbox masks and free-first rule; 0: global mask and first-match rule (sampled at frame accept) |
| glb_mask | input | IDW | Global acceptance mask |
| frm_valid | input | 1 | Frame present |
| frm_ready | output | 1 | Engine can take a frame |
| frm_id | input | IDW | Frame identifier |
| frm_ext | input | 1 | Frame extended flag |
| res_valid | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | Frame was stored |
| res_idx | output | IW | Winning mailbox |
| cfg_we | input | 1 | Mailbox setup write |
| cfg_idx | input | IW | Mailbox to set up |
| cfg_code | input | 3 | Code: 0 INACTIVE, 1 EMPTY, 2 FULL, 3 OVERRUN, 4 TX |
| cfg_id | input | IDW | Identifier to store |
| cfg_ext | input | 1 | Extended flag to store |
| cfg_mask | input | IDW | Per-mailbox mask to store |
| lock_req | input | 1 | CPU reads and locks `lock_idx` (releases any previous lock) |
| lock_idx | input | IW | Mailbox to lock |
| unlock_req | input | 1 | Release the current lock |
| irq_clr | input | NMB | Write-1-to-clear for interrupt flags |
| irq_flags | output | NMB | Sticky per-mailbox interrupt flags |
| rd_idx | input | IW | Mailbox to observe |
| rd_code | output | 3 | Code of `rd_idx` |
| rd_id | output | IDW | Identifier of `rd_idx` |
| rd_ext | output | 1 | Extended flag of `rd_idx` |

## Verification
Frames of both kinds are sent at mixed standard and extended mailboxes. This shows the extended-flag gate and the don't-care role of a zero mask. A partial mask that one identifier passes and another fails shows that bits are compared only where the mask has a 1. Repeated identical frames in global mode separate the first-match rule from the free-first rule, because they keep landing in one mailbox and drive it to OVERRUN. In individual mode the same repetition fills mailboxes in order and then falls back to the last occupied one. Read-unlock, hold-lock and TX-coded neighbours then show that serviced mailboxes win again, that locked ones are skipped and that non-receive codes are ignored.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

  typedef enum logic [2:0] {
    MB_INACTIVE = 3'd0,
    MB_EMPTY    = 3'd1,
    MB_FULL     = 3'd2,
    MB_OVERRUN  = 3'd3,
    MB_TX       = 3'd4
  } mb_code_e;

  typedef enum logic [1:0] {
    SEL_IDLE  = 2'd0,
    SEL_SCAN  = 2'd1,
    SEL_STORE = 2'd2
  } sel_state_e;

  function automatic logic is_rx_code(input logic [2:0] c);
    return (c == MB_EMPTY) || (c == MB_FULL) || (c == MB_OVERRUN);
  endfunction

  function automatic logic is_loaded(input logic [2:0] c);
    return (c == MB_FULL) || (c == MB_OVERRUN);
  endfunction

endpackage

// File: rtl/can_mb_bank.sv
module can_mb_bank
  import can_rx_pkg::*;
#(
  parameter int NMB = 8,
  parameter int IDW = 29
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NMB)-1:0]   cfg_idx,
  input  logic [2:0]               cfg_code,
  input  logic [IDW-1:0]           cfg_id,
  input  logic                     cfg_ext,
  input  logic [IDW-1:0]           cfg_mask,
  input  logic                     lock_req,
  input  logic [$clog2(NMB)-1:0]   lock_idx,
  input  logic                     unlock_req,
  input  logic                     st_en,
  input  logic [$clog2(NMB)-1:0]   st_idx,
  input  logic [IDW-1:0]           st_id,
  input  logic [NMB-1:0]           irq_clr,
  output logic [2:0]               code_q [NMB],
  output logic [IDW-1:0]           id_q   [NMB],
  output logic [NMB-1:0]           ext_q,
  output logic [IDW-1:0]           mask_q [NMB],
  output logic [NMB-1:0]           free_q,
  output logic                     lk_valid,
  output logic [$clog2(NMB)-1:0]   lk_idx,
  output logic [NMB-1:0]           irq_q
);

  localparam int IW = $clog2(NMB);

  // A lock ends on an explicit unlock or when a new read replaces it.
  logic rel;
  assign rel = lk_valid && (unlock_req || lock_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_valid <= 1'b0;
      lk_idx   <= '0;
    end else if (lock_req) begin
      lk_valid <= 1'b1;
      lk_idx   <= lock_idx;
    end else if (unlock_req) begin
      lk_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NMB; g++) begin : g_mb
    logic [2:0]     code_r;
    logic [IDW-1:0] id_r;
    logic           ext_r;
    logic [IDW-1:0] mask_r;
    logic           serv_r;
    logic           irq_r;
    logic           cfg_hit;
    logic           st_hit;
    logic           rel_hit;

    assign cfg_hit = cfg_we && (cfg_idx == IW'(g));
    assign st_hit  = st_en && (st_idx == IW'(g));
    assign rel_hit = rel && (lk_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_r <= MB_INACTIVE;
        id_r   <= '0;
        ext_r  <= 1'b0;
        mask_r <= '0;
        serv_r <= 1'b0;
      end else if (cfg_hit) begin
        code_r <= cfg_code;
        id_r   <= cfg_id;
        ext_r  <= cfg_ext;
        mask_r <= cfg_mask;
        serv_r <= 1'b0;
      end else if (st_hit) begin
        id_r   <= st_id;
        code_r <= free_q[g] ? MB_FULL : MB_OVERRUN;
        serv_r <= 1'b0;
      end else if (rel_hit && is_loaded(code_r)) begin
        serv_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) irq_r <= 1'b0;
      else        irq_r <= (irq_r && !irq_clr[g]) || st_hit;
    end

    assign code_q[g] = code_r;
    assign id_q[g]   = id_r;
    assign ext_q[g]  = ext_r;
    assign mask_q[g] = mask_r;
    assign irq_q[g]  = irq_r;
    assign free_q[g] = (code_r == MB_EMPTY) || (is_loaded(code_r) && serv_r);
  end

endmodule

// File: rtl/can_mb_match.sv
module can_mb_match
  import can_rx_pkg::*;
#(
  parameter int IDW = 29
) (
  input  logic [2:0]     mb_code,
  input  logic [IDW-1:0] mb_id,
  input  logic           mb_ext,
  input  logic [IDW-1:0] mb_mask,
  input  logic           mb_locked,
  input  logic [IDW-1:0] f_id,
  input  logic           f_ext,
  output logic           hit
);

  logic [IDW-1:0] diff;

  always_comb begin
    diff = (f_id ^ mb_id) & mb_mask;
    hit  = is_rx_code(mb_code) && (mb_ext == f_ext) && (diff == '0) && !mb_locked;
  end

endmodule

// File: rtl/can_win_sel.sv
module can_win_sel
  import can_rx_pkg::*;
#(
  parameter int NMB = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   indiv,
  input  logic                   hit,
  input  logic                   free,
  output logic                   busy,
  output logic [$clog2(NMB)-1:0] scan_idx,
  output logic                   store_phase,
  output logic                   win_valid,
  output logic [$clog2(NMB)-1:0] win_idx
);

  localparam int IW = $clog2(NMB);
  localparam logic [IW-1:0] LAST = IW'(NMB - 1);

  sel_state_e     state;
  logic           mode_q;
  logic           have_first, have_free, have_busy;
  logic [IW-1:0]  first_idx, free_idx, busy_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SEL_IDLE;
      mode_q     <= 1'b0;
      scan_idx   <= '0;
      have_first <= 1'b0;
      have_free  <= 1'b0;
      have_busy  <= 1'b0;
      first_idx  <= '0;
      free_idx   <= '0;
      busy_idx   <= '0;
    end else begin
      case (state)
        SEL_IDLE: begin
          if (start) begin
            state      <= SEL_SCAN;
            mode_q     <= indiv;
            scan_idx   <= '0;
            have_first <= 1'b0;
            have_free  <= 1'b0;
            have_busy  <= 1'b0;
          end
        end
        SEL_SCAN: begin
          if (hit) begin
            if (!have_first) begin
              have_first <= 1'b1;
              first_idx  <= scan_idx;
            end
            if (free && !have_free) begin
              have_free <= 1'b1;
              free_idx  <= scan_idx;
            end
            if (!free) begin
              have_busy <= 1'b1;
              busy_idx  <= scan_idx;
            end
          end
          if (scan_idx == LAST) state <= SEL_STORE;
          else                  scan_idx <= scan_idx + 1'b1;
        end
        SEL_STORE: state <= SEL_IDLE;
        default:   state <= SEL_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state != SEL_IDLE);
    store_phase = (state == SEL_STORE);
    if (mode_q) begin
      win_valid = have_free || have_busy;
      win_idx   = have_free ? free_idx : busy_idx;
    end else begin
      win_valid = have_first;
      win_idx   = first_idx;
    end
  end

endmodule

// File: rtl/can_rx_match.sv
module can_rx_match
  import can_rx_pkg::*;
#(
  parameter int NMB = 8,
  parameter int IDW = 29
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   indiv_en,
  input  logic [IDW-1:0]         glb_mask,
  input  logic                   frm_valid,
  output logic                   frm_ready,
  input  logic [IDW-1:0]         frm_id,
  input  logic                   frm_ext,
  output logic                   res_valid,
  output logic                   res_hit,
  output logic [$clog2(NMB)-1:0] res_idx,
  input  logic                   cfg_we,
  input  logic [$clog2(NMB)-1:0] cfg_idx,
  input  logic [2:0]             cfg_code,
  input  logic [IDW-1:0]         cfg_id,
  input  logic                   cfg_ext,
  input  logic [IDW-1:0]         cfg_mask,
  input  logic                   lock_req,
  input  logic [$clog2(NMB)-1:0] lock_idx,
  input  logic                   unlock_req,
  input  logic [NMB-1:0]         irq_clr,
  output logic [NMB-1:0]         irq_flags,
  input  logic [$clog2(NMB)-1:0] rd_idx,
  output logic [2:0]             rd_code,
  output logic [IDW-1:0]         rd_id,
  output logic                   rd_ext
);

  localparam int IW = $clog2(NMB);

  logic [2:0]     code_q [NMB];
  logic [IDW-1:0] id_q   [NMB];
  logic [NMB-1:0] ext_q;
  logic [IDW-1:0] mask_q [NMB];
  logic [NMB-1:0] free_q;
  logic           lk_valid;
  logic [IW-1:0]  lk_idx;

  logic           busy, store_phase, win_valid;
  logic [IW-1:0]  scan_idx, win_idx;
  logic           start, hit, st_en;
  logic [IDW-1:0] f_id;
  logic           f_ext, f_indiv;
  logic [IDW-1:0] sel_mask;
  logic           sel_locked;
  logic [2:0]     res_code_w;

  assign frm_ready = !busy;
  assign start     = frm_valid && frm_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_id    <= '0;
      f_ext   <= 1'b0;
      f_indiv <= 1'b0;
    end else if (start) begin
      f_id    <= frm_id;
      f_ext   <= frm_ext;
      f_indiv <= indiv_en;
    end
  end

  assign sel_mask   = f_indiv ? mask_q[scan_idx] : glb_mask;
  assign sel_locked = lk_valid && (lk_idx == scan_idx);

  can_mb_match #(.IDW(IDW)) u_match (
    .mb_code   (code_q[scan_idx]),
    .mb_id     (id_q[scan_idx]),
    .mb_ext    (ext_q[scan_idx]),
    .mb_mask   (sel_mask),
    .mb_locked (sel_locked),
    .f_id      (f_id),
    .f_ext     (f_ext),
    .hit       (hit)
  );

  can_win_sel #(.NMB(NMB)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .indiv       (indiv_en),
    .hit         (hit),
    .free        (free_q[scan_idx]),
    .busy        (busy),
    .scan_idx    (scan_idx),
    .store_phase (store_phase),
    .win_valid   (win_valid),
    .win_idx     (win_idx)
  );

  // Re-check the winner at the store cycle: a fresh lock or setup write cancels it.
  assign st_en = store_phase && win_valid
               && !(lk_valid && (lk_idx == win_idx))
               && !(cfg_we && (cfg_idx == win_idx))
               && is_rx_code(code_q[win_idx]);

  can_mb_bank #(.NMB(NMB), .IDW(IDW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_code   (cfg_code),
    .cfg_id     (cfg_id),
    .cfg_ext    (cfg_ext),
    .cfg_mask   (cfg_mask),
    .lock_req   (lock_req),
    .lock_idx   (lock_idx),
    .unlock_req (unlock_req),
    .st_en      (st_en),
    .st_idx     (win_idx),
    .st_id      (f_id),
    .irq_clr    (irq_clr),
    .code_q     (code_q),
    .id_q       (id_q),
    .ext_q      (ext_q),
    .mask_q     (mask_q),
    .free_q     (free_q),
    .lk_valid   (lk_valid),
    .lk_idx     (lk_idx),
    .irq_q      (irq_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= store_phase;
      res_hit   <= st_en;
      res_idx   <= win_idx;
    end
  end

  assign rd_code    = code_q[rd_idx];
  assign rd_id      = id_q[rd_idx];
  assign rd_ext     = ext_q[rd_idx];
  assign res_code_w = code_q[res_idx];

endmodule

// File: rtl/can_rx_match_chk.sv
module can_rx_match_chk #(
  parameter int NMB = 8,
  parameter int IDW = 29
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   frm_valid,
  input logic                   frm_ready,
  input logic                   res_valid,
  input logic                   res_hit,
  input logic [$clog2(NMB)-1:0] res_idx,
  input logic [NMB-1:0]         irq_flags,
  input logic [NMB-1:0]         irq_clr,
  input logic                   lk_valid,
  input logic [$clog2(NMB)-1:0] lk_idx,
  input logic [2:0]             res_code
);

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_ready); // R1

  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> frm_ready); // R1

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R2

  AST_STORE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_code == 3'd2 || res_code == 3'd3)); // R8

  AST_NO_LOCKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> !($past(lk_valid) && ($past(lk_idx) == res_idx))); // R10

  AST_IRQ_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> irq_flags[res_idx]); // R11

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_flags) & ~irq_flags & ~$past(irq_clr)) == '0)); // R11

endmodule

bind can_rx_match can_rx_match_chk #(.NMB(NMB), .IDW(IDW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .irq_flags (irq_flags),
  .irq_clr   (irq_clr),
  .lk_valid  (lk_valid),
  .lk_idx    (lk_idx),
  .res_code  (res_code_w)
);

// File: tb/can_rx_match_bench.sv
module can_rx_match_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMB = 8;
  localparam int IDW = 29;
  localparam int IW  = $clog2(NMB);

  localparam logic [2:0] C_INA = 3'd0, C_EMP = 3'd1, C_FUL = 3'd2, C_OVR = 3'd3, C_TX = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic indiv_en = 1'b0;
  logic [IDW-1:0] glb_mask = '0;
  logic frm_valid = 1'b0;
  logic frm_ready;
  logic [IDW-1:0] frm_id = '0;
  logic frm_ext = 1'b0;
  logic res_valid, res_hit;
  logic [IW-1:0] res_idx;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [2:0] cfg_code = '0;
  logic [IDW-1:0] cfg_id = '0;
  logic cfg_ext = 1'b0;
  logic [IDW-1:0] cfg_mask = '0;
  logic lock_req = 1'b0;
  logic [IW-1:0] lock_idx = '0;
  logic unlock_req = 1'b0;
  logic [NMB-1:0] irq_clr = '0;
  logic [NMB-1:0] irq_flags;
  logic [IW-1:0] rd_idx = '0;
  logic [2:0] rd_code;
  logic [IDW-1:0] rd_id;
  logic rd_ext;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_match #(.NMB(NMB), .IDW(IDW)) u_can_rx_match (
    .clk(clk), .rst_n(rst_n), .indiv_en(indiv_en), .glb_mask(glb_mask),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_id(frm_id), .frm_ext(frm_ext),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code), .cfg_id(cfg_id),
    .cfg_ext(cfg_ext), .cfg_mask(cfg_mask), .lock_req(lock_req), .lock_idx(lock_idx),
    .unlock_req(unlock_req), .irq_clr(irq_clr), .irq_flags(irq_flags),
    .rd_idx(rd_idx), .rd_code(rd_code), .rd_id(rd_id), .rd_ext(rd_ext)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_mb(input int idx, input logic [2:0] code, input logic [IDW-1:0] id,
                        input logic ext, input logic [IDW-1:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_code = code; cfg_id = id; cfg_ext = ext; cfg_mask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic all_inactive();
    for (int i = 0; i < NMB; i++) cfg_mb(i, C_INA, '0, 1'b0, '0);
    @(negedge clk);
    irq_clr = '1;
    @(negedge clk);
    irq_clr = '0;
  endtask

  task automatic do_lock(input int idx);
    @(negedge clk);
    lock_req = 1'b1; lock_idx = IW'(idx);
    @(negedge clk);
    lock_req = 1'b0;
  endtask

  task automatic do_unlock();
    @(negedge clk);
    unlock_req = 1'b1;
    @(negedge clk);
    unlock_req = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [2:0] code, output logic [IDW-1:0] id);
    rd_idx = IW'(idx);
    #1;
    code = rd_code;
    id = rd_id;
  endtask

  task automatic send(input string req, input logic [IDW-1:0] id, input logic ext,
                      input logic exp_hit, input int exp_idx);
    int cyc;
    @(negedge clk);
    check("R1", "ready before send", frm_ready, 1);
    frm_valid = 1'b1; frm_id = id; frm_ext = ext;
    @(posedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
    check("R1", "ready low while scanning", frm_ready, 0);
    cyc = 0;
    while (!res_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check("R2", "result latency", cyc, NMB + 1);
    check(req, "hit", res_hit, exp_hit);
    if (exp_hit) check(req, "winner", res_idx, exp_idx);
    check("R1", "ready with result", frm_ready, 1);
    @(negedge clk);
    check("R2", "pulse one cycle", res_valid, 0);
  endtask

  task automatic t_reset();
    logic [2:0] c; logic [IDW-1:0] d;
    check("R12", "ready after reset", frm_ready, 1);
    check("R12", "irq after reset", irq_flags, 0);
    peek(0, c, d); check("R12", "mb0 code", c, C_INA);
    peek(NMB-1, c, d); check("R12", "last mb code", c, C_INA);
  endtask

  task automatic t_ide_mask();
    logic [2:0] c; logic [IDW-1:0] d;
    indiv_en = 1'b1;
    cfg_mb(0, C_EMP, '0, 1'b0, '0);
    cfg_mb(1, C_EMP, '0, 1'b1, '0);
    send("R4", 29'h1ABCDEF, 1'b1, 1'b1, 1);
    peek(1, c, d);
    check("R8", "ext mb code FULL", c, C_FUL);
    check("R8", "ext mb id", d, 29'h1ABCDEF);
    send("R4", 29'h123, 1'b0, 1'b1, 0);
    peek(0, c, d);
    check("R3", "zero mask takes any id", d, 29'h123);
    check("R11", "irq both", irq_flags, 8'b0000_0011);
    @(negedge clk); irq_clr = 8'b0000_0001;
    @(negedge clk); irq_clr = '0;
    check("R11", "w1c clears one", irq_flags, 8'b0000_0010);
    cfg_mb(0, C_INA, '0, 1'b0, '0);
    cfg_mb(2, C_EMP, 29'h0F0, 1'b0, 29'h0F0);
    send("R3", 29'h3F5, 1'b0, 1'b1, 2);
    send("R3", 29'h305, 1'b0, 1'b0, 0);
    peek(2, c, d);
    check("R9", "no-match keeps code", c, C_FUL);
    check("R9", "no-match keeps id", d, 29'h3F5);
    check("R9", "no-match keeps irq", irq_flags, 8'b0000_0110);
  endtask

  task automatic t_global();
    logic [2:0] c; logic [IDW-1:0] d;
    all_inactive();
    indiv_en = 1'b0;
    glb_mask = '1;
    cfg_mb(3, C_EMP, 29'h55, 1'b1, '0);
    cfg_mb(5, C_EMP, 29'h55, 1'b1, '0);
    send("R5", 29'h55, 1'b1, 1'b1, 3);
    send("R5", 29'h55, 1'b1, 1'b1, 3);
    peek(3, c, d);
    check("R8", "repeat store OVERRUN", c, C_OVR);
    peek(5, c, d);
    check("R5", "later match untouched", c, C_EMP);
    do_lock(3);
    do_unlock();
    send("R7", 29'h55, 1'b1, 1'b1, 3);
    peek(3, c, d);
    check("R7", "serviced store FULL", c, C_FUL);
    // per-mailbox mask is zero, so only the global mask can reject this
    send("R5", 29'h56, 1'b1, 1'b0, 0);
    check("R9", "irq unchanged", irq_flags, 8'b0000_1000);
  endtask

  task automatic t_indiv();
    logic [2:0] c; logic [IDW-1:0] d;
    all_inactive();
    indiv_en = 1'b1;
    for (int i = 2; i < 6; i++) cfg_mb(i, C_EMP, '0, 1'b1, '0);
    cfg_mb(6, C_TX, '0, 1'b1, '0);
    cfg_mb(1, C_EMP, '0, 1'b0, '0);
    for (int i = 2; i < 6; i++) send("R6", IDW'(29'h1000 + i), 1'b1, 1'b1, i);
    // mb6 is TX-coded: the last-occupied fallback must stop at 5 (R9)
    send("R6", 29'h2222, 1'b1, 1'b1, 5);
    peek(5, c, d);
    check("R8", "fallback OVERRUN", c, C_OVR);
    check("R8", "fallback id", d, 29'h2222);
    peek(6, c, d);
    check("R9", "TX mb untouched", c, C_TX);
    do_lock(3);
    do_unlock();
    send("R7", 29'h3333, 1'b1, 1'b1, 3);
    peek(3, c, d);
    check("R7", "serviced becomes FULL", c, C_FUL);
  endtask

  task automatic t_lock();
    logic [2:0] c; logic [IDW-1:0] d;
    cfg_mb(2, C_EMP, '0, 1'b1, '0);
    do_lock(2);
    send("R10", 29'h4444, 1'b1, 1'b1, 5);
    peek(2, c, d);
    check("R10", "locked mb untouched", c, C_EMP);
    do_unlock();
    send("R10", 29'h5555, 1'b1, 1'b1, 2);
    @(negedge clk); irq_clr = '1;
    @(negedge clk); irq_clr = '0;
    check("R11", "clear all", irq_flags, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ide_mask();
    t_global();
    t_indiv();
    t_lock();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule